// File: doc/BRIEF.md
# One-Hot Select Rotate and Window Shifter

This block is a purely combinational switch-array shifter with two independent halves. Both halves take a one-hot select word in which each line stands for one shift position. The first half rotates a 4-bit word left. Bits move from lower indices toward higher indices, and the top bits wrap round to the bottom. The second half takes an 8-bit word and passes out one of four 4-bit windows of adjacent bits. The select line that is active picks the window's starting index.

Neither half stores anything, and each output follows its inputs with no clock. Each half checks its own select word. When the select has no line active, or more than one, that half drives its data output to zero and raises its own illegal-select flag. The block suits datapaths that already hold the shift amount as a decoded one-hot vector.

Top module: `shift_switch_top`

## Requirements
- R1: When rot_sel has exactly bit k set (k in 0..3), rot_out[i] equals rot_in[(i-k) mod 4] for every i in 0..3, so bits move toward higher indices and wrap round.
- R2: When rot_sel is 4'b0001, rot_out equals rot_in. When rot_sel is 4'b0010, rot_out equals {rot_in[2:0], rot_in[3]}.
- R3: When rot_sel is 4'b0000 or has two or more bits set, rot_out is 4'b0000 and rot_bad is 1. When exactly one bit is set, rot_bad is 0.
- R4: When win_sel has exactly bit k set (k in 0..3), win_out[i] equals win_in[i+k] for every i in 0..3, so bit k of win_sel selects win_in[k+3:k].
- R5: When win_sel is 4'b0000 or has two or more bits set, win_out is 4'b0000 and win_bad is 1. When exactly one bit is set, win_bad is 0.
- R6: Every output depends only on the present inputs. After any change of input, the outputs settle to the values above with no clock edge.
- R7: The two halves are independent. rot_in and rot_sel have no effect on win_out or win_bad, and win_in and win_sel have no effect on rot_out or rot_bad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rot_in | input | 4 | Word to rotate |
| rot_sel | input | 4 | One-hot rotate amount, bit k rotates left by k |
| rot_out | output | 4 | Rotated word, zero on an illegal select |
| rot_bad | output | 1 | Rotate select is not one-hot |
| win_in | input | 8 | Wide source word |
| win_sel | input | 4 | One-hot window start, bit k starts at index k |
| win_out | output | 4 | Selected 4-bit window, zero on an illegal select |
| win_bad | output | 1 | Window select is not one-hot |

## Verification
The hardest case to reach is a select word with several lines active while the data carries a pattern that would let a wrong OR of two paths look correct. If the data is all zeros or all ones, a merged output matches the expected zero or rotated value by chance. The stimulus therefore sweeps every data value against all sixteen select codes for both halves. It then drives random illegal selects on one half while the other half holds a legal select with known data, which shows that a fault in one half cannot reach the other half's outputs.

// File: rtl/shift_switch_pkg.sv
package shift_switch_pkg;

    localparam int unsigned ROT_W_DEF = 4;
    localparam int unsigned WIN_N_DEF = 4;

    typedef struct packed {
        logic [ROT_W_DEF-1:0] rot;
        logic                 rot_bad;
        logic [WIN_N_DEF-1:0] win;
        logic                 win_bad;
    } shift_out_t;

endpackage

// File: rtl/sel_guard.sv
module sel_guard #(
    parameter int unsigned SEL_W = 4
) (
    input  logic [SEL_W-1:0] sel,
    output logic             legal
);
    localparam int unsigned CNT_W = $clog2(SEL_W + 1);

    logic [CNT_W-1:0] ones_d;

    always_comb begin
        ones_d = '0;
        for (int unsigned k = 0; k < SEL_W; k++) begin
            ones_d = ones_d + CNT_W'(sel[k]);
        end
        legal = (ones_d == CNT_W'(1));
    end
endmodule

// File: rtl/rotl_array.sv
module rotl_array #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] din,
    input  logic [W-1:0] sel,
    input  logic         en,
    output logic [W-1:0] dout
);
    genvar i, k;
    generate
        for (i = 0; i < W; i++) begin : g_out
            logic [W-1:0] taps;
            for (k = 0; k < W; k++) begin : g_tap
                localparam int unsigned SRC = (i + W - k) % W;
                assign taps[k] = sel[k] & din[SRC];
            end
            assign dout[i] = en & (|taps);
        end
    endgenerate
endmodule

// File: rtl/window_array.sv
module window_array #(
    parameter int unsigned N = 4
) (
    input  logic [2*N-1:0] din,
    input  logic [N-1:0]   sel,
    input  logic           en,
    output logic [N-1:0]   dout
);
    genvar i, k;
    generate
        for (i = 0; i < N; i++) begin : g_out
            logic [N-1:0] taps;
            for (k = 0; k < N; k++) begin : g_tap
                assign taps[k] = sel[k] & din[i+k];
            end
            assign dout[i] = en & (|taps);
        end
    endgenerate
endmodule

// File: rtl/shift_switch_top.sv
module shift_switch_top
    import shift_switch_pkg::*;
(
    input  logic [ROT_W_DEF-1:0]   rot_in,
    input  logic [ROT_W_DEF-1:0]   rot_sel,
    output logic [ROT_W_DEF-1:0]   rot_out,
    output logic                   rot_bad,
    input  logic [2*WIN_N_DEF-1:0] win_in,
    input  logic [WIN_N_DEF-1:0]   win_sel,
    output logic [WIN_N_DEF-1:0]   win_out,
    output logic                   win_bad
);
    logic rot_ok, win_ok;
    logic [ROT_W_DEF-1:0] rot_raw;
    logic [WIN_N_DEF-1:0] win_raw;
    shift_out_t res_d;

    sel_guard #(.SEL_W(ROT_W_DEF)) u_rot_guard (.sel(rot_sel), .legal(rot_ok));
    sel_guard #(.SEL_W(WIN_N_DEF)) u_win_guard (.sel(win_sel), .legal(win_ok));

    rotl_array #(.W(ROT_W_DEF)) u_rot (
        .din(rot_in), .sel(rot_sel), .en(rot_ok), .dout(rot_raw)
    );

    window_array #(.N(WIN_N_DEF)) u_win (
        .din(win_in), .sel(win_sel), .en(win_ok), .dout(win_raw)
    );

    always_comb begin
        res_d.rot     = rot_raw;
        res_d.rot_bad = ~rot_ok;
        res_d.win     = win_raw;
        res_d.win_bad = ~win_ok;
    end

    assign rot_out = res_d.rot;
    assign rot_bad = res_d.rot_bad;
    assign win_out = res_d.win;
    assign win_bad = res_d.win_bad;
endmodule

// File: rtl/shift_switch_chk.sv
module shift_switch_chk (
    input logic [3:0] rot_in,
    input logic [3:0] rot_sel,
    input logic [3:0] rot_out,
    input logic       rot_bad,
    input logic [7:0] win_in,
    input logic [3:0] win_sel,
    input logic [3:0] win_out,
    input logic       win_bad
);
    always_comb begin
        a_r3_blank_on_bad: assert (!rot_bad || rot_out == 4'b0000)
            else $error("R3: rot_out not blank while rot_bad");
        a_r3_single_ok: assert (($countones(rot_sel) != 1) || !rot_bad)
            else $error("R3: rot_bad on one-hot select");
        a_r1_ones_kept: assert (rot_bad || ($countones(rot_out) == $countones(rot_in)))
            else $error("R1: rotation changed the number of ones");
        a_r2_identity: assert ((rot_sel != 4'b0001) || (rot_out == rot_in))
            else $error("R2: zero rotate not identity");
        a_r5_blank_on_bad: assert (!win_bad || win_out == 4'b0000)
            else $error("R5: win_out not blank while win_bad");
        a_r5_flag_multi: assert (($countones(win_sel) == 1) || win_bad)
            else $error("R5: win_bad missing");
        a_r4_low_window: assert ((win_sel != 4'b0001) || (win_out == win_in[3:0]))
            else $error("R4: first window wrong");
    end
endmodule

bind shift_switch_top shift_switch_chk u_chk (
    .rot_in(rot_in), .rot_sel(rot_sel), .rot_out(rot_out), .rot_bad(rot_bad),
    .win_in(win_in), .win_sel(win_sel), .win_out(win_out), .win_bad(win_bad)
);

// File: tb/tb_shift_switch_top.sv
module tb_shift_switch_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [3:0] rot_in, rot_sel, rot_out;
    logic       rot_bad;
    logic [7:0] win_in;
    logic [3:0] win_sel, win_out;
    logic       win_bad;

    int checks = 0;
    int errors = 0;
    int unsigned cyc = 0;
    bit done = 1'b0;

    shift_switch_top dut (
        .rot_in(rot_in), .rot_sel(rot_sel), .rot_out(rot_out), .rot_bad(rot_bad),
        .win_in(win_in), .win_sel(win_sel), .win_out(win_out), .win_bad(win_bad)
    );

    function automatic logic [4:0] exp_rot(input logic [3:0] a, input logic [3:0] s);
        logic [3:0] y = '0;
        if ($countones(s) != 1) return {4'b0000, 1'b1};
        for (int k = 0; k < 4; k++)
            if (s[k])
                for (int i = 0; i < 4; i++) y[i] = a[(i - k + 4) % 4];
        return {y, 1'b0};
    endfunction

    function automatic logic [4:0] exp_win(input logic [7:0] d, input logic [3:0] s);
        logic [3:0] y = '0;
        if ($countones(s) != 1) return {4'b0000, 1'b1};
        for (int k = 0; k < 4; k++)
            if (s[k])
                for (int i = 0; i < 4; i++) y[i] = d[i + k];
        return {y, 1'b0};
    endfunction

    task automatic cmp(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] a, input logic [3:0] rs,
                         input logic [7:0] d, input logic [3:0] ws);
        rot_in = a; rot_sel = rs; win_in = d; win_sel = ws;
        #2;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] hold_w;
        void'($urandom(32'd1234));
        // R6: settled outputs right after first drive
        apply(4'b1011, 4'b0001, 8'hA5, 4'b0001);
        cmp("R2 identity", {rot_out, rot_bad}, {4'b1011, 1'b0});
        cmp("R6 initial window", {win_out, win_bad}, {4'b0101, 1'b0});
        apply(4'b1000, 4'b0010, 8'hA5, 4'b1000);
        cmp("R2 rotate by one wraps", {rot_out, rot_bad}, {4'b0001, 1'b0});
        cmp("R4 top window", {win_out, win_bad}, {4'b0100, 1'b0});
        apply(4'b1011, 4'b0000, 8'hFF, 4'b0000);
        cmp("R3 zero select", {rot_out, rot_bad}, {4'b0000, 1'b1});
        cmp("R5 zero select", {win_out, win_bad}, {4'b0000, 1'b1});
        apply(4'b1111, 4'b1111, 8'hFF, 4'b0110);
        cmp("R3 all select", {rot_out, rot_bad}, {4'b0000, 1'b1});
        cmp("R5 double select", {win_out, win_bad}, {4'b0000, 1'b1});

        // R1, R3 exhaustive rotate; R4, R5 exhaustive window
        for (int a = 0; a < 16; a++)
            for (int s = 0; s < 16; s++) begin
                apply(4'(a), 4'(s), 8'h3C, 4'b0100);
                cmp("R1 R3 rotate sweep", {rot_out, rot_bad}, exp_rot(4'(a), 4'(s)));
            end
        for (int d = 0; d < 256; d++)
            for (int s = 0; s < 16; s++) begin
                apply(4'b0110, 4'b0100, 8'(d), 4'(s));
                cmp("R4 R5 window sweep", {win_out, win_bad}, exp_win(8'(d), 4'(s)));
            end

        // R7: random activity on one half while other half is held
        apply(4'b1001, 4'b0100, 8'b1011_0110, 4'b0010);
        hold_w = exp_win(8'b1011_0110, 4'b0010);
        for (int n = 0; n < 200; n++) begin
            logic [3:0] ra = 4'($urandom);
            logic [3:0] rs = 4'($urandom);
            apply(ra, rs, 8'b1011_0110, 4'b0010);
            cmp("R7 window unaffected", {win_out, win_bad}, hold_w);
            cmp("R1 R3 random rotate", {rot_out, rot_bad}, exp_rot(ra, rs));
        end
        for (int n = 0; n < 200; n++) begin
            logic [7:0] wd = 8'($urandom);
            logic [3:0] ws = 4'($urandom);
            apply(4'b1001, 4'b0100, wd, ws);
            cmp("R7 rotate unaffected", {rot_out, rot_bad}, exp_rot(4'b1001, 4'b0100));
            cmp("R4 R5 random window", {win_out, win_bad}, exp_win(wd, ws));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule